// File: doc/BRIEF.md
# Motor Predriver Protection Sequencer

This block sequences the operating state of a PWM motor gate predriver. It chooses between sleep, run and fault, and it decides whether the external power switch may be driven. A separate PWM generator supplies a strobe once per PWM period, together with a flag that says whether current limiting cut that period short. Two comparator flags report supply under-voltage and over-voltage. A command-activity pulse shows that the speed input is still present.

Over-current is handled in episodes. When current limiting persists for a programmable number of consecutive PWM periods, the gate is forced off for a programmable number of periods. The block then restarts automatically, once. If a second episode follows before a clean run window has passed, the fault latches. It is released only when the command input goes away, which puts the block to sleep, and then comes back.

Top module: `mtp_protect_fsm`

## Requirements
- R1: After reset the block is in sleep: `state_o` = 2'b00 (2'b00 sleep, 2'b01 run, 2'b10 fault), `run_en` = 0, `gate_off` = 1.
- R2: With both supply flags low, the block enters run (`run_en` = 1, `gate_off` = 0) within two clocks of a `cmd_act` pulse.
- R3: If no `cmd_act` pulse arrives for ALIVE_CLKS clocks, the block drops to sleep. It wakes again when activity resumes.
- R4: A high `uv_flag` puts the block into sleep with the gate off at the next clock. When the flag clears and activity is present, the block returns to run by itself.
- R5: A high `ov_flag` with `uv_flag` low forces fault with the gate off at the next clock. When the flag clears, the block returns to run, or to the latched fault if one is pending.
- R6: Under-voltage outranks over-voltage: with both flags high the block sleeps. Both flags outrank the over-current logic.
- R7: In run, LIMIT_PERIODS consecutive strobes with `cur_lim` high cause fault. One strobe fewer does not.
- R8: A strobe with `cur_lim` low resets the consecutive-limit count to zero.
- R9: A first over-current fault keeps the gate off for HOLD_PERIODS strobes, whatever the value of `cur_lim`, and then restarts into run.
- R10: A second consecutive over-current episode latches the fault. Strobes and over-voltage cycles do not release it. Only sleep followed by activity does, and the block then returns to run.
- R11: LIMIT_PERIODS strobes in run without a fault clear the retry memory, so the next episode gets a restart again.
- R12: Entering sleep clears the retry memory, all counters and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_stb | input | 1 | One-cycle pulse per PWM period |
| cur_lim | input | 1 | Current limit was hit in the period marked by pwm_stb |
| uv_flag | input | 1 | Supply below the under-voltage threshold |
| ov_flag | input | 1 | Supply above the over-voltage threshold |
| cmd_act | input | 1 | Command input activity pulse |
| run_en | output | 1 | PWM gate drive enabled |
| gate_off | output | 1 | Gate forced low |
| state_o | output | 2 | 00 sleep, 01 run, 10 fault |

## Verification
The assertions take `cur_lim` to be meaningful only when `pwm_stb` is high. They also take the comparator flags to be already clean digital levels that need no filtering. The stimulus meets both conditions. Strobes are single-cycle pulses with an idle cycle between them. The limit flag is driven only together with a strobe, and the supply flags change only at negative clock edges and stay steady for at least one full cycle. A background process pulses activity every eight clocks, well inside the alive window, except where a test removes activity on purpose.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
   typedef enum logic [2:0] {
      ST_SLEEP = 3'd0,
      ST_RUN   = 3'd1,
      ST_HOLD  = 3'd2,
      ST_LATCH = 3'd3,
      ST_OVF   = 3'd4
   } mtp_state_e;

   localparam logic [1:0] CODE_SLEEP = 2'b00;
   localparam logic [1:0] CODE_RUN   = 2'b01;
   localparam logic [1:0] CODE_FAULT = 2'b10;

   function automatic logic [1:0] coarse_code(mtp_state_e s);
      case (s)
         ST_SLEEP: coarse_code = CODE_SLEEP;
         ST_RUN:   coarse_code = CODE_RUN;
         default:  coarse_code = CODE_FAULT;
      endcase
   endfunction
endpackage

// File: rtl/mtp_alive_mon.sv
module mtp_alive_mon #(
   parameter int unsigned ALIVE_CLKS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act,
   output logic alive
);
   localparam int unsigned W = $clog2(ALIVE_CLKS + 1);
   localparam logic [W-1:0] CAP = W'(ALIVE_CLKS);

   generate
      if (ALIVE_CLKS < 2) begin : g_bad_alive
         $error("ALIVE_CLKS must be at least 2");
      end
   endgenerate

   logic [W-1:0] idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              idle_q <= CAP;
      else if (act)            idle_q <= '0;
      else if (idle_q != CAP)  idle_q <= idle_q + 1'b1;
   end

   assign alive = (idle_q != CAP);
endmodule

// File: rtl/mtp_stb_cnt.sv
module mtp_stb_cnt #(
   parameter int unsigned TERMINAL = 64000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic hit
);
   localparam int unsigned W = $clog2(TERMINAL + 1);
   localparam logic [W-1:0] LAST = W'(TERMINAL - 1);

   generate
      if (TERMINAL < 2) begin : g_bad_term
         $error("TERMINAL must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   assign hit = inc && !clr && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (clr || hit) cnt_q <= '0;
      else if (inc)        cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/mtp_protect_fsm.sv
module mtp_protect_fsm #(
   parameter int unsigned LIMIT_PERIODS = 64000,
   parameter int unsigned HOLD_PERIODS  = 64000,
   parameter int unsigned ALIVE_CLKS    = 2048
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_stb,
   input  logic       cur_lim,
   input  logic       uv_flag,
   input  logic       ov_flag,
   input  logic       cmd_act,
   output logic       run_en,
   output logic       gate_off,
   output logic [1:0] state_o
);
   import mtp_pkg::*;

   mtp_state_e st_q, st_d;
   logic       retry_q, retry_d;
   logic       latch_q, latch_d;
   logic       alive_w;
   logic       lim_hit, hold_hit, win_hit;
   logic       in_run, in_hold;

   assign in_run  = (st_q == ST_RUN);
   assign in_hold = (st_q == ST_HOLD);

   mtp_alive_mon #(.ALIVE_CLKS(ALIVE_CLKS)) u_alive (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (cmd_act),
      .alive (alive_w)
   );

   // consecutive current-limited periods
   mtp_stb_cnt #(.TERMINAL(LIMIT_PERIODS)) u_limcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_run || (pwm_stb && !cur_lim)),
      .inc   (pwm_stb && cur_lim),
      .hit   (lim_hit)
   );

   // periods spent with the gate held off after a first episode
   mtp_stb_cnt #(.TERMINAL(HOLD_PERIODS)) u_holdcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_hold),
      .inc   (pwm_stb),
      .hit   (hold_hit)
   );

   // clean-run window that forgets an earlier episode
   mtp_stb_cnt #(.TERMINAL(LIMIT_PERIODS)) u_wincnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!in_run),
      .inc   (pwm_stb),
      .hit   (win_hit)
   );

   always_comb begin
      st_d    = st_q;
      retry_d = retry_q;
      latch_d = latch_q;
      if (uv_flag || !alive_w) begin
         st_d    = ST_SLEEP;
         retry_d = 1'b0;
         latch_d = 1'b0;
      end else if (ov_flag) begin
         st_d = ST_OVF;
      end else begin
         case (st_q)
            ST_SLEEP: st_d = ST_RUN;
            ST_RUN: begin
               if (lim_hit) begin
                  if (retry_q) begin
                     st_d    = ST_LATCH;
                     latch_d = 1'b1;
                  end else begin
                     st_d    = ST_HOLD;
                     retry_d = 1'b1;
                  end
               end else if (win_hit) begin
                  retry_d = 1'b0;
               end
            end
            ST_HOLD:  if (hold_hit) st_d = ST_RUN;
            ST_LATCH: st_d = ST_LATCH;
            ST_OVF:   st_d = latch_q ? ST_LATCH : ST_RUN;
            default:  st_d = ST_SLEEP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_SLEEP;
         retry_q <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         retry_q <= retry_d;
         latch_q <= latch_d;
      end
   end

   assign run_en   = in_run;
   assign gate_off = !in_run;
   assign state_o  = coarse_code(st_q);
endmodule

// File: rtl/mtp_guard_chk.sv
module mtp_guard_chk (
   input logic                clk,
   input logic                rst_n,
   input logic                uv,
   input logic                ov,
   input logic                alive,
   input logic                stb,
   input logic                lim,
   input mtp_pkg::mtp_state_e st,
   input logic                gate_off,
   input logic [1:0]          state_o
);
   import mtp_pkg::*;

   // R4
   uv_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv |=> (state_o == 2'b00) && gate_off);

   // R6
   uv_over_ov_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uv && ov) |=> (state_o == 2'b00));

   // R5
   ov_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv && alive && ov) |=> (state_o == 2'b10) && gate_off);

   // R3
   idle_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !alive |=> (state_o == 2'b00));

   // R10
   latch_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LATCH && !uv && alive) |=> (state_o == 2'b10));

   // R7
   hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_HOLD) |-> $past(stb && lim));

   // R9
   hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st == ST_HOLD) && st == ST_RUN) |-> $past(stb));
endmodule

bind mtp_protect_fsm mtp_guard_chk u_guard (
   .clk      (clk),
   .rst_n    (rst_n),
   .uv       (uv_flag),
   .ov       (ov_flag),
   .alive    (alive_w),
   .stb      (pwm_stb),
   .lim      (cur_lim),
   .st       (st_q),
   .gate_off (gate_off),
   .state_o  (state_o)
);

// File: tb/sim_mtp_protect_fsm.sv
`timescale 1ns/1ps
module sim_mtp_protect_fsm;
   localparam int LIM  = 8;
   localparam int HOLD = 6;
   localparam int ALV  = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_stb = 1'b0, cur_lim = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
   logic cmd_act = 1'b0;
   logic act_en = 1'b0;
   logic run_en, gate_off;
   logic [1:0] state_o;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   mtp_protect_fsm #(.LIMIT_PERIODS(LIM), .HOLD_PERIODS(HOLD), .ALIVE_CLKS(ALV)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_stb(pwm_stb), .cur_lim(cur_lim),
      .uv_flag(uv_flag), .ov_flag(ov_flag), .cmd_act(cmd_act),
      .run_en(run_en), .gate_off(gate_off), .state_o(state_o));

   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph = ph + 1;
         cmd_act = act_en && (ph % 8 == 0);
      end
   end

   task automatic chk(input string tag, input logic [1:0] exp_st);
      logic exp_run;
      exp_run = (exp_st == 2'b01);
      n_chk++;
      if (state_o !== exp_st || run_en !== exp_run || gate_off !== !exp_run) begin
         n_fail++;
         $display("FAIL %s: state=%b run=%b goff=%b expected state=%b run=%b goff=%b",
                  tag, state_o, run_en, gate_off, exp_st, exp_run, !exp_run);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input logic l, input int n);
      for (int i = 0; i < n; i++) begin
         pwm_stb = 1'b1; cur_lim = l;
         @(negedge clk);
         pwm_stb = 1'b0; cur_lim = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      tick(3); rst_n = 1'b1; tick(3);
      chk("R1 reset sleep", 2'b00);
   endtask

   task automatic t_wake();
      act_en = 1'b1; tick(12);
      chk("R2 wake to run", 2'b01);
   endtask

   task automatic t_alive();
      act_en = 1'b0; tick(20);
      chk("R3 still alive inside window", 2'b01);
      tick(20);
      chk("R3 idle to sleep", 2'b00);
      act_en = 1'b1; tick(12);
      chk("R3 rewake", 2'b01);
   endtask

   task automatic t_uv();
      uv_flag = 1'b1; tick(1);
      chk("R4 uv sleep", 2'b00);
      tick(3);
      chk("R4 uv held", 2'b00);
      uv_flag = 1'b0; tick(1);
      chk("R4 uv recovery", 2'b01);
   endtask

   task automatic t_ov();
      ov_flag = 1'b1; tick(1);
      chk("R5 ov fault", 2'b10);
      ov_flag = 1'b0; tick(1);
      chk("R5 ov recovery", 2'b01);
   endtask

   task automatic t_prio();
      uv_flag = 1'b1; ov_flag = 1'b1; tick(1);
      chk("R6 uv over ov", 2'b00);
      uv_flag = 1'b0; tick(1);
      chk("R6 ov after uv", 2'b10);
      ov_flag = 1'b0; tick(1);
      chk("R6 back to run", 2'b01);
   endtask

   task automatic t_limit();
      strobe(1'b1, LIM - 1);
      chk("R7 one short of limit", 2'b01);
      strobe(1'b0, 1);
      strobe(1'b1, LIM - 1);
      chk("R8 clean period restarts count", 2'b01);
      strobe(1'b1, 1);
      chk("R7 limit reached fault", 2'b10);
   endtask

   task automatic t_hold();
      strobe(1'b1, HOLD - 1);
      chk("R9 hold not yet over", 2'b10);
      strobe(1'b0, 1);
      chk("R9 auto restart", 2'b01);
   endtask

   task automatic t_latch();
      strobe(1'b1, LIM);
      chk("R10 second episode fault", 2'b10);
      strobe(1'b0, HOLD + 4);
      chk("R10 latched after hold time", 2'b10);
      ov_flag = 1'b1; tick(2); ov_flag = 1'b0; tick(2);
      chk("R10 latched after ov cycle", 2'b10);
      act_en = 1'b0; tick(45);
      chk("R10 sleep on lost command", 2'b00);
      act_en = 1'b1; tick(12);
      chk("R10 released by sleep", 2'b01);
   endtask

   task automatic t_sleep_clear();
      strobe(1'b1, LIM);
      strobe(1'b0, HOLD);
      chk("R12 restart after first episode", 2'b01);
      uv_flag = 1'b1; tick(1); uv_flag = 1'b0; tick(1);
      chk("R12 back from sleep", 2'b01);
      strobe(1'b1, LIM);
      strobe(1'b0, HOLD);
      chk("R12 retry cleared by sleep", 2'b01);
   endtask

   task automatic t_window();
      strobe(1'b0, LIM);
      strobe(1'b1, LIM);
      chk("R11 episode after clean window", 2'b10);
      strobe(1'b0, HOLD);
      chk("R11 restart granted", 2'b01);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_wake();
            t_alive();
            t_uv();
            t_ov();
            t_prio();
            t_limit();
            t_hold();
            t_latch();
            t_sleep_clear();
            t_window();
         end
         begin
            #(200000 * 20);
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule